// File: doc/BRIEF.md
# Vectored Interrupt Controller with Two-Level Pin Masking

The block gathers eleven interrupt request sources and presents the most urgent pending one to a processor as a 4-bit vector index with a request line. Three kinds of source feed it. Single-cycle event pulses come from a bus-reset detector, five endpoint engines and a serial interface. Two timer bits (a 128 µs tap and a 1.024 ms tap) raise a request on each low-to-high transition. Two pin groups, one DAC-side input port and a set of GPIO ports, raise a request on a pin edge.

Each pin group has its own pin-level enable mask, applied ahead of the per-source enable. The DAC port picks the edge direction for each pin. The GPIO ports pick one direction per port, and that direction applies to every pin of the port. Pin and timer inputs pass through one register before edge detection, so one transition yields exactly one pending set.

Every request lands in a sticky pending bit that holds until the processor acknowledges that vector index. A per-source enable decides which pending bits compete in arbitration. A global enable gates the request line.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every pending bit is clear, irq_o is 0 and vec_o is 0.
- R2: Vector indices: bus reset is 0, endpoints 0..4 are 3..7, and serial is 10. Each of these event inputs sets its pending bit at the rising clock edge that samples it high, so irq_o and vec_o reflect it directly after that edge.
- R3: The 128 µs timer bit is vector 1 and the 1.024 ms bit is vector 2. Only a 0-to-1 transition sets pending, and the result is visible after the second rising edge following the change. A 1-to-0 transition has no effect.
- R4: The DAC pin group is vector 8. A pin edge sets pending only if the pin's bit in dac_pin_en_i is 1 and the edge matches the pin's bit in dac_pol_i (0 = rising, 1 = falling). Latency is the same as in R3.
- R5: The GPIO pin group is vector 9. Pin p*GPIO_W+b belongs to port p. An edge sets pending only if the pin's bit in gpio_pin_en_i is 1 and the edge matches gpio_pol_i[p] (0 = rising, 1 = falling). Latency is the same as in R3.
- R6: A pending bit stays set until a clock edge with ack_i=1 and ack_vec_i equal to its index. An acknowledge of another index, or of an index of 11 or above, leaves it set. A set and an acknowledge of the same index at the same edge leave it set.
- R7: A pending source whose bit in src_en_i is 0 is not presented, but it stays pending. Setting that enable bit presents it with no new event.
- R8: When several enabled sources are pending, vec_o is the lowest index among them.
- R9: irq_o is 1 exactly when glb_en_i is 1 and at least one pending source is enabled. Clearing glb_en_i keeps all pending bits.
- R10: A pin or timer level that is held after its edge never sets pending again, so one edge produces one pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rst_evt_i | input | 1 | Bus-reset event pulse |
| tick128_i | input | 1 | 128 µs timer bit |
| tick1024_i | input | 1 | 1.024 ms timer bit |
| ep_evt_i | input | 5 | Endpoint event pulses |
| ser_evt_i | input | 1 | Serial-interface event pulse |
| dac_pins_i | input | DAC_W | DAC port pin levels |
| dac_pin_en_i | input | DAC_W | DAC per-pin enable |
| dac_pol_i | input | DAC_W | DAC per-pin edge select, 1 = falling |
| gpio_pins_i | input | GPIO_PORTS*GPIO_W | GPIO pin levels |
| gpio_pin_en_i | input | GPIO_PORTS*GPIO_W | GPIO per-pin enable |
| gpio_pol_i | input | GPIO_PORTS | GPIO per-port edge select, 1 = falling |
| src_en_i | input | 11 | Per-source enable |
| glb_en_i | input | 1 | Global request enable |
| ack_i | input | 1 | Acknowledge strobe |
| ack_vec_i | input | 4 | Index being acknowledged |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 4 | Winning vector index |

## Verification
Event pulses are due directly after the rising edge that samples them. Pin and timer edges are due after the second rising edge, because one edge fills the input register and the next one loads pending. An acknowledge takes effect at the next edge, and enable changes act combinationally on the stored state. The bench drives every input on a falling edge and samples on a later falling edge after counting the rising edges in between. For the pin paths it also checks for a low request one edge early. Cases that must be ignored are checked after at least three edges have passed.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 11;
  localparam int VEC_W   = 4;
  localparam int NUM_EP  = 5;
  localparam int SRC_BUS = 0;
  localparam int SRC_T128 = 1;
  localparam int SRC_T1K = 2;
  localparam int SRC_EP0 = 3;
  localparam int SRC_DAC = 8;
  localparam int SRC_GPIO = 9;
  localparam int SRC_SER = 10;
endpackage

// File: rtl/irq_edge_group.sv
module irq_edge_group #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= pins_i;
      prev_q <= cur_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit_o[i] = en_i[i] & (pol_i[i] ? (~cur_q[i] & prev_q[i])
                                          : (cur_q[i] & ~prev_q[i]));
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= set_i | (pend_o & ~clr_i);  // set wins
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 11,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int DAC_W      = 8,
  parameter int GPIO_PORTS = 2,
  parameter int GPIO_W     = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bus_rst_evt_i,
  input  logic                         tick128_i,
  input  logic                         tick1024_i,
  input  logic [4:0]                   ep_evt_i,
  input  logic                         ser_evt_i,
  input  logic [DAC_W-1:0]             dac_pins_i,
  input  logic [DAC_W-1:0]             dac_pin_en_i,
  input  logic [DAC_W-1:0]             dac_pol_i,
  input  logic [GPIO_PORTS*GPIO_W-1:0] gpio_pins_i,
  input  logic [GPIO_PORTS*GPIO_W-1:0] gpio_pin_en_i,
  input  logic [GPIO_PORTS-1:0]        gpio_pol_i,
  input  logic [10:0]                  src_en_i,
  input  logic                         glb_en_i,
  input  logic                         ack_i,
  input  logic [3:0]                   ack_vec_i,
  output logic                         irq_o,
  output logic [3:0]                   vec_o
);
  localparam int GPIO_N = GPIO_PORTS * GPIO_W;

  logic [NUM_SRC-1:0] set_w, clr_w, pend_q, live_w;
  logic [1:0]         tick_hit;
  logic [DAC_W-1:0]   dac_hit;
  logic [GPIO_N-1:0]  gpio_hit, gpio_pol_pin;
  logic               any_live;

  irq_edge_group #(.W(2)) i_tick_edge (
    .clk_i, .rst_ni,
    .pins_i({tick1024_i, tick128_i}),
    .pol_i (2'b00),
    .en_i  (2'b11),
    .hit_o (tick_hit)
  );

  irq_edge_group #(.W(DAC_W)) i_dac_edge (
    .clk_i, .rst_ni,
    .pins_i(dac_pins_i),
    .pol_i (dac_pol_i),
    .en_i  (dac_pin_en_i),
    .hit_o (dac_hit)
  );

  for (genvar p = 0; p < GPIO_PORTS; p++) begin : g_gpio_pol
    assign gpio_pol_pin[p*GPIO_W +: GPIO_W] = {GPIO_W{gpio_pol_i[p]}};
  end

  irq_edge_group #(.W(GPIO_N)) i_gpio_edge (
    .clk_i, .rst_ni,
    .pins_i(gpio_pins_i),
    .pol_i (gpio_pol_pin),
    .en_i  (gpio_pin_en_i),
    .hit_o (gpio_hit)
  );

  always_comb begin
    set_w = '0;
    set_w[SRC_BUS]  = bus_rst_evt_i;
    set_w[SRC_T128] = tick_hit[0];
    set_w[SRC_T1K]  = tick_hit[1];
    for (int e = 0; e < NUM_EP; e++) set_w[SRC_EP0 + e] = ep_evt_i[e];
    set_w[SRC_DAC]  = |dac_hit;
    set_w[SRC_GPIO] = |gpio_hit;
    set_w[SRC_SER]  = ser_evt_i;
  end

  always_comb begin
    clr_w = '0;
    if (ack_i && (ack_vec_i < VEC_W'(NUM_SRC))) clr_w[ack_vec_i] = 1'b1;
  end

  irq_pend #(.N(NUM_SRC)) i_pend (
    .clk_i, .rst_ni,
    .set_i (set_w),
    .clr_i (clr_w),
    .pend_o(pend_q)
  );

  assign live_w = pend_q & src_en_i;

  irq_prio_enc #(.N(NUM_SRC), .IW(VEC_W)) i_prio (
    .req_i(live_w),
    .any_o(any_live),
    .idx_o(vec_o)
  );

  assign irq_o = glb_en_i & any_live;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int N  = 11,
  parameter int VW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  set_i,
  input logic [N-1:0]  pend_i,
  input logic [N-1:0]  src_en_i,
  input logic          glb_en_i,
  input logic          ack_i,
  input logic [VW-1:0] ack_vec_i,
  input logic          irq_o,
  input logic [VW-1:0] vec_o
);
  logic [N-1:0] live;
  logic [N-1:0] below;
  assign live  = pend_i & src_en_i;
  assign below = (N'(1) << vec_o) - N'(1);

  for (genvar i = 0; i < N; i++) begin : g_src
    AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_i[i]); // R2
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i[i] && !(ack_i && ack_vec_i == VW'(i))) |=> pend_i[i]); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && ack_vec_i == VW'(i) && !set_i[i]) |=> !pend_i[i]); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_i[i]) |-> $past(set_i[i])); // R10
  end

  AST_VEC_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> live[vec_o]); // R7
  AST_PRIO_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((live & below) == '0)); // R8
  AST_GLB_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |-> !irq_o); // R9
  AST_REQ_WHEN_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en_i && live != '0) |-> irq_o); // R9
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.N(11), .VW(4)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .set_i     (set_w),
  .pend_i    (pend_q),
  .src_en_i  (src_en_i),
  .glb_en_i  (glb_en_i),
  .ack_i     (ack_i),
  .ack_vec_i (ack_vec_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o)
);

// File: tb/test_irq_vec_ctrl.sv
`timescale 1ns/1ps
module test_irq_vec_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rst_evt_i = 0, tick128_i = 0, tick1024_i = 0, ser_evt_i = 0;
  logic [4:0]  ep_evt_i = '0;
  logic [7:0]  dac_pins_i = '0, dac_pin_en_i = '0, dac_pol_i = '0;
  logic [15:0] gpio_pins_i = '0, gpio_pin_en_i = '0;
  logic [1:0]  gpio_pol_i = '0;
  logic [10:0] src_en_i = '1;
  logic        glb_en_i = 1'b1, ack_i = 1'b0;
  logic [3:0]  ack_vec_i = '0;
  logic        irq_o;
  logic [3:0]  vec_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_vec_ctrl i_irq_vec_ctrl (.*);

  task automatic step(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_req(string tag, int irq, int vec);
    chk({tag, " irq"}, int'(irq_o), irq);
    if (irq != 0) chk({tag, " vec"}, int'(vec_o), vec);
  endtask

  task automatic ack(int v);
    ack_i = 1'b1; ack_vec_i = 4'(v);
    step();
    ack_i = 1'b0;
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 in reset irq", int'(irq_o), 0);
    chk("R1 in reset vec", int'(vec_o), 0);
    rst_ni = 1'b1;
    step();
    chk("R1 after release irq", int'(irq_o), 0);
    chk("R1 after release vec", int'(vec_o), 0);
  endtask

  task automatic t_events();
    ep_evt_i = 5'b00100; step(); ep_evt_i = '0;
    chk_req("R2 endpoint2", 1, 5);
    ack(5);
    chk_req("R6 ack endpoint2", 0, 0);
    ser_evt_i = 1; step(); ser_evt_i = 0;
    chk_req("R2 serial", 1, 10);
    ack(4);
    chk_req("R6 other index kept", 1, 10);
    ack(15);
    chk_req("R6 out-of-range kept", 1, 10);
    ack(10);
    bus_rst_evt_i = 1; step(); bus_rst_evt_i = 0;
    chk_req("R2 bus reset", 1, 0);
    ack(0);
    chk_req("R6 ack bus reset", 0, 0);
  endtask

  task automatic t_timer();
    tick128_i = 1; step();
    chk_req("R3 not yet after one edge", 0, 0);
    step();
    chk_req("R3 tick128 rise", 1, 1);
    ack(1);
    step(3);
    chk_req("R10 tick128 held high", 0, 0);
    tick128_i = 0; step(3);
    chk_req("R3 tick128 fall ignored", 0, 0);
    tick1024_i = 1; step(2);
    chk_req("R3 tick1024 rise", 1, 2);
    ack(2);
    tick1024_i = 0; step(3);
    chk_req("R3 tick1024 fall ignored", 0, 0);
  endtask

  task automatic t_prio();
    bus_rst_evt_i = 1; ep_evt_i = 5'b00001; ser_evt_i = 1;
    step();
    bus_rst_evt_i = 0; ep_evt_i = '0; ser_evt_i = 0;
    chk_req("R8 three pending", 1, 0);
    ack(0);
    chk_req("R8 next", 1, 3);
    ack(3);
    chk_req("R8 last", 1, 10);
    ack(10);
    chk_req("R8 drained", 0, 0);
  endtask

  task automatic t_mask();
    src_en_i = 11'h3FF;
    ser_evt_i = 1; step(); ser_evt_i = 0;
    chk_req("R7 disabled source hidden", 0, 0);
    step(2);
    src_en_i = '1; step();
    chk_req("R7 enable presents kept", 1, 10);
    ack(10);
    glb_en_i = 0;
    ep_evt_i = 5'b10000; step(); ep_evt_i = '0;
    chk_req("R9 global off", 0, 0);
    glb_en_i = 1; step();
    chk_req("R9 global on keeps pending", 1, 7);
    ack(7);
  endtask

  task automatic t_same_edge();
    ep_evt_i = 5'b00010; step(); ep_evt_i = '0;
    chk_req("R2 endpoint1", 1, 4);
    ep_evt_i = 5'b00010; ack_i = 1; ack_vec_i = 4;
    step();
    ep_evt_i = '0; ack_i = 0;
    chk_req("R6 set wins over ack", 1, 4);
    ack(4);
    chk_req("R6 cleared", 0, 0);
  endtask

  task automatic t_dac();
    dac_pin_en_i = 8'h0F;
    dac_pins_i = 8'h20; step(3);
    chk_req("R4 disabled pin ignored", 0, 0);
    dac_pins_i = 8'h22; step();
    chk_req("R4 not yet after one edge", 0, 0);
    step();
    chk_req("R4 rising pin1", 1, 8);
    ack(8);
    step(3);
    chk_req("R10 dac held level", 0, 0);
    dac_pol_i = 8'h02; step(2);
    chk_req("R4 polarity change alone", 0, 0);
    dac_pins_i = 8'h20; step(2);
    chk_req("R4 falling pin1", 1, 8);
    ack(8);
    dac_pins_i = 8'h24; step(3);
    dac_pins_i = 8'h20; step(3);
    chk_req("R4 pin2 wrong direction fall", 1, 8);
    ack(8);
    dac_pins_i = 8'h00; step(3);
    chk_req("R4 quiet", 0, 0);
  endtask

  task automatic t_gpio();
    gpio_pin_en_i = 16'hFFEF;
    gpio_pol_i = 2'b10; step();
    gpio_pins_i = 16'h1000; step(3);
    chk_req("R5 port1 rise ignored", 0, 0);
    gpio_pins_i = 16'h0000; step(2);
    chk_req("R5 port1 fall", 1, 9);
    ack(9);
    gpio_pins_i = 16'h0008; step(2);
    chk_req("R5 port0 rise", 1, 9);
    ack(9);
    gpio_pins_i = 16'h0018; step(3);
    chk_req("R5 disabled pin4 ignored", 0, 0);
    gpio_pins_i = 16'h0010; step(3);
    chk_req("R5 port0 fall ignored", 0, 0);
  endtask

  initial begin
    t_reset();
    t_events();
    t_timer();
    t_prio();
    t_mask();
    t_same_edge();
    t_dac();
    t_gpio();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule